// File: doc/BRIEF.md
# SPI Interrupt Flag and Mask Unit

This unit sits beside an SPI controller's transfer engine and turns three one-cycle event pulses (frame sequence complete, receive data ready, receive overrun) into sticky raw flags. Each flag is gated by an enable bit taken from the controller's control word. The gated result is offered as a masked view and is OR-reduced onto one interrupt line.

The enable bits do not sit in the same order as the flags. They live at control bits 4 to 6 and are permuted onto flag positions 0 to 2 before gating. Software reads the raw and masked views through a small register port. It acknowledges flags by writing ones to a clear address. Writes aimed at the read-only views are dropped.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Raw flag bit 0 is frame sequence complete, bit 1 is receive data ready and bit 2 is receive overrun. A pulse on `evt_set_i[k]` sets raw flag k at the next clock edge. Reading address 1 returns the raw flags in bits 2:0 with zeros above.
- R2: The enable for raw bit 0 is control bit 5. The enable for raw bit 1 is control bit 4. The enable for raw bit 2 is control bit 6. No other control bit affects gating.
- R3: Reading address 2 returns, in bits 2:0, the bitwise AND of the permuted enables and the raw flags, with zeros above. The view follows the control input in the same cycle.
- R4: `irq_o` is high exactly when at least one masked bit is set.
- R5: A write to address 0 with data bit k set (k = 0..2) clears raw flag k at the next edge. Data bits that are zero leave their flags unchanged.
- R6: Writes to address 1, 2 or 3 change no flag, whatever their data.
- R7: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: A synchronous active-high reset clears all raw flags, so `irq_o` is low after it.
- R9: A raw flag stays set until it is cleared or reset. Masking it does not clear it.
- R10: Reading address 0 or address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 3 | One-cycle set pulses, bit order as in R1 |
| ctrl_i | input | CTRL_W (32) | Controller control word; bits 4..6 are enables |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W (2) | Write address |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_raddr_i | input | ADDR_W (2) | Read address |
| reg_rdata_o | output | DATA_W (32) | Read data, combinational from the read address |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench tests each enable bit alone, so a design that gated flags in the plain order (bit 4 with flag 0) would raise the interrupt for the wrong flag. It clears with mixed ones and zeros, which catches a clear that wipes every flag or ignores zero bits. It writes all-ones to the read-only addresses, which catches a decoder that lets those writes clear flags. It collides a set and a clear on one flag, which catches a design where the clear wins. It also masks a set flag and then unmasks it, which catches a design that drops the flag when it is masked.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_EVT = 3;

    // Flag positions inside the raw and masked views
    localparam int FLAG_DONE  = 0;
    localparam int FLAG_RXRDY = 1;
    localparam int FLAG_OVF   = 2;

    // Register addresses
    localparam int ADDR_CLEAR  = 0;
    localparam int ADDR_RAW    = 1;
    localparam int ADDR_MASKED = 2;

    typedef logic [NUM_EVT-1:0] flag_vec_t;

    typedef struct packed {
        logic      hit;
        flag_vec_t bits;
    } clr_req_t;

    // Control-word bit that enables each flag (non-ordered permutation)
    function automatic int en_pos(input int flag);
        case (flag)
            FLAG_DONE:  en_pos = 5;
            FLAG_RXRDY: en_pos = 4;
            default:    en_pos = 6;
        endcase
    endfunction

endpackage

// File: rtl/spi_irq_en_remap.sv
module spi_irq_en_remap
    import spi_irq_pkg::*;
#(
    parameter int CTRL_W = 32
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output flag_vec_t         en_o
);
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_i;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_map
        assign en_o[g] = ctrl_i[en_pos(g)];
    end

endmodule

// File: rtl/spi_irq_flag_bank.sv
module spi_irq_flag_bank
    import spi_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_i,
    input  clr_req_t  clr_i,
    output flag_vec_t raw_o
);
    flag_vec_t clr_bits;
    assign clr_bits = clr_i.hit ? clr_i.bits : '0;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (set_i[g]) begin
                flag_q <= 1'b1;
            end else if (clr_bits[g]) begin
                flag_q <= 1'b0;
            end
        end

        assign raw_o[g] = flag_q;

        // Set pulse sets the flag even when a clear hits it too (R1, R7)
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> raw_o[g]);

        // Clear without set empties the flag (R5)
        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_i.hit && clr_i.bits[g] && !set_i[g]) |=> !raw_o[g]);

        // Flag is sticky unless cleared (R9)
        assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            (raw_o[g] && !(clr_i.hit && clr_i.bits[g])) |=> raw_o[g]);
    end

endmodule

// File: rtl/spi_irq_read_mux.sv
module spi_irq_read_mux
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] raddr_i,
    input  flag_vec_t         raw_i,
    input  flag_vec_t         masked_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (raddr_i == ADDR_W'(ADDR_RAW)) begin
            rdata_o = DATA_W'(raw_i);
        end else if (raddr_i == ADDR_W'(ADDR_MASKED)) begin
            rdata_o = DATA_W'(masked_i);
        end
    end

    // Views other than raw and masked read as zero (R10)
    always_comb begin
        if (raddr_i != ADDR_W'(ADDR_RAW) && raddr_i != ADDR_W'(ADDR_MASKED)) begin
            assert_zero_read_R10: assert (rdata_o == '0);
        end
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        evt_set_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_waddr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic [ADDR_W-1:0] reg_raddr_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    flag_vec_t raw;
    flag_vec_t en;
    flag_vec_t masked;
    clr_req_t  clr_req;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i;

    assign clr_req.hit  = reg_wr_i && (reg_waddr_i == ADDR_W'(ADDR_CLEAR));
    assign clr_req.bits = reg_wdata_i[NUM_EVT-1:0];

    spi_irq_en_remap #(.CTRL_W(CTRL_W)) u_remap (
        .ctrl_i (ctrl_i),
        .en_o   (en)
    );

    spi_irq_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_set_i),
        .clr_i (clr_req),
        .raw_o (raw)
    );

    assign masked = raw & en;
    assign irq_o  = |masked;

    spi_irq_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmux (
        .raddr_i  (reg_raddr_i),
        .raw_i    (raw),
        .masked_i (masked),
        .rdata_o  (reg_rdata_o)
    );

    // Interrupt line against the control port with the permutation (R2, R4)
    always_comb begin
        assert_irq_map_R4: assert (irq_o ==
            ((raw[FLAG_DONE] & ctrl_i[5]) | (raw[FLAG_RXRDY] & ctrl_i[4]) |
             (raw[FLAG_OVF] & ctrl_i[6])));
    end

    // Writes outside the clear address leave flags alone (R6)
    assert_ro_write_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_waddr_i != ADDR_W'(ADDR_CLEAR) && evt_set_i == '0)
        |=> $stable(raw));

    // Reset empties every flag (R8)
    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q === 1'b1) begin
            assert_reset_R8: assert (raw == '0 && !irq_o);
        end
    end

endmodule

// File: tb/spi_irq_ctrl_test.sv
`timescale 1ns/1ps
module spi_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  evt = '0;
    logic [31:0] ctrl = '0;
    logic        wr = 1'b0;
    logic [1:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  raddr = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int m_raw  = 0;

    always #2.5 clk = ~clk;

    spi_irq_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .evt_set_i   (evt),
        .ctrl_i      (ctrl),
        .reg_wr_i    (wr),
        .reg_waddr_i (waddr),
        .reg_wdata_i (wdata),
        .reg_raddr_i (raddr),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic int m_en();
        return (ctrl[5] ? 1 : 0) | (ctrl[4] ? 2 : 0) | (ctrl[6] ? 4 : 0);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input string tag, input bit r, input int e, input int c,
                        input bit w, input int wa, input int wd, input int ra);
        int exp_rd;
        rst = r; evt = 3'(e); ctrl = 32'(c); wr = w;
        waddr = 2'(wa); wdata = 32'(wd); raddr = 2'(ra);
        @(posedge clk);
        if (r) m_raw = 0;
        else m_raw = (m_raw & ~((w && wa == 0) ? (wd & 7) : 0)) | (e & 7);
        @(negedge clk);
        case (ra)
            1: exp_rd = m_raw;
            2: exp_rd = m_raw & m_en();
            default: exp_rd = 0;
        endcase
        check(tag, int'(rdata), exp_rd);
        check({tag, "/R4"}, int'(irq), ((m_raw & m_en()) != 0) ? 1 : 0);
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R8: reset state
        step("R8", 1, 0, 32'h70, 0, 0, 0, 1);
        step("R8", 1, 7, 32'h70, 0, 0, 0, 2);
        // R1: each event sets its own raw flag
        step("R1", 0, 1, 0, 0, 0, 0, 1);
        step("R1", 0, 2, 0, 0, 0, 0, 1);
        step("R1", 0, 4, 0, 0, 0, 0, 1);
        // R9: masked flags remain set, irq low
        step("R9", 0, 0, 0, 0, 0, 0, 1);
        // R2/R3: one enable at a time
        step("R2", 0, 0, 32'h20, 0, 0, 0, 2);
        step("R2", 0, 0, 32'h10, 0, 0, 0, 2);
        step("R2", 0, 0, 32'h40, 0, 0, 0, 2);
        step("R3", 0, 0, 32'hFFFF_FF8F, 0, 0, 0, 2);
        // R10: clear and spare addresses read zero
        step("R10", 0, 0, 32'h70, 0, 0, 0, 0);
        step("R10", 0, 0, 32'h70, 0, 0, 0, 3);
        // R6: writes to read-only addresses ignored
        step("R6", 0, 0, 32'h70, 1, 1, 32'hFFFF_FFFF, 1);
        step("R6", 0, 0, 32'h70, 1, 2, 32'hFFFF_FFFF, 1);
        step("R6", 0, 0, 32'h70, 1, 3, 32'hFFFF_FFFF, 1);
        // R5: partial clear, zeros ignored
        step("R5", 0, 0, 32'h70, 1, 0, 32'hFFFF_FFF2, 1);
        step("R5", 0, 0, 32'h70, 1, 0, 0, 1);
        step("R5", 0, 0, 32'h20, 0, 0, 0, 2);
        step("R5", 0, 0, 32'h70, 1, 0, 5, 1);
        // R7: set and clear collide
        step("R7", 0, 2, 32'h10, 1, 0, 7, 1);
        step("R7", 0, 4, 32'h10, 1, 0, 6, 2);
        step("R7", 0, 0, 32'h40, 0, 0, 0, 2);
        // R9: mask then unmask keeps flag
        step("R9", 0, 0, 0, 0, 0, 0, 2);
        step("R9", 0, 0, 32'h50, 0, 0, 0, 2);
        // mixed patterns
        for (int i = 0; i < 16; i++) begin
            step("R3", 0, i % 8, (i * 32'h13) & 32'h7F, (i % 3) == 0, i % 4,
                 (i * 5) % 8, (i + 1) % 4);
        end
        // R8: reset mid-run
        step("R1", 0, 7, 32'h70, 0, 0, 0, 1);
        step("R8", 1, 0, 32'h70, 0, 0, 0, 1);
        step("R8", 0, 0, 32'h70, 0, 0, 0, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule